// File: doc/BRIEF.md
# Two-Level Loop DMA Channel Engine

This block is the transfer engine of a single DMA channel. A descriptor held on configuration inputs sets a source address, a destination address, a transfer size for each side, a per-request byte count (the inner loop), an outer iteration count, and two signed end-of-run address adjustments. Each service request runs one inner loop. Source reads of one size are packed into destination writes of another size, and both addresses advance by their access size after each accepted access.

An outer counter counts finished inner loops. After the last one, the adjustments are added to both addresses, the counter reloads, the done flag rises and an interrupt flag is latched. Software can trigger service with a start pulse, and a peripheral can trigger it with a request pulse while requests are enabled. A trigger that arrives during service waits until the running inner loop ends.

Memory is reached through one request channel with valid/ready. The engine holds `mem_req_valid`, the address, the size, the direction and the write data unchanged until `mem_req_ready` is seen high at a clock edge. A write is complete at that edge. A read is complete when `mem_rsp_valid` is high at a later edge; the response has no ready signal. No new request is issued while a read is outstanding. The descriptor inputs must stay constant while `sts_active` is high.

Top module: `dma_nested_loop_chan`

## Requirements
- R1: Size codes 0, 1 and 2 mean 1, 2 and 4 bytes. Read data arrives in the lowest lanes. The bytes of successive reads are packed from lane 0 upward into each write, and each write carries exactly its size in the lowest lanes with upper lanes zero. The destination bytes equal the source bytes in address order.
- R2: Each accepted read advances the source address by the source size. Each accepted write advances the destination address by the destination size.
- R3: One trigger runs one inner loop of `cfg_minor_bytes` bytes. Service start clears done and sets active, and active falls when the inner loop ends.
- R4: `cur_iter` loads from `cfg_major_iters` on `cfg_load` and decrements at the end of each inner loop. When an inner loop ends with `cur_iter` equal to 1, `cur_iter` reloads from `cfg_major_iters`.
- R5: At outer completion, the signed final adjustments are added to both addresses. Adjustments equal to minus the total byte count restore the starting addresses.
- R6: At outer completion, done is set and the interrupt flag is latched. Active and done are never high together.
- R7: `irq` is the latched flag gated by `int_en`. The flag is kept while `int_en` is low.
- R8: `int_clr` clears the flag. When `int_clr` falls in the same cycle as an outer completion, the flag stays set.
- R9: A start pulse, or a peripheral request, that arrives during service is held and starts the next inner loop after the current one ends.
- R10: `hw_req` has no effect while `hw_req_en` is low, and it is not remembered for later.
- R11: If a size code is above 2, the byte count is zero or not a multiple of the larger size, or the iteration count is zero, a trigger sets `sts_cfg_err`, is dropped, and issues no memory access. `cfg_load` clears the error.
- R12: A request that is not accepted holds its valid, address and direction. No request is issued while a read awaits its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src_addr | input | AW | Starting source address |
| cfg_dst_addr | input | AW | Starting destination address |
| cfg_src_size | input | 2 | Source access size code |
| cfg_dst_size | input | 2 | Destination access size code |
| cfg_minor_bytes | input | BC_W | Bytes per inner loop |
| cfg_major_iters | input | IT_W | Inner loops per outer run |
| cfg_src_final_adj | input | AW | Signed source adjustment at outer completion |
| cfg_dst_final_adj | input | AW | Signed destination adjustment at outer completion |
| cfg_load | input | 1 | Load addresses and counter from the descriptor while idle |
| sw_start | input | 1 | Software trigger pulse |
| hw_req | input | 1 | Peripheral trigger pulse |
| hw_req_en | input | 1 | Enables peripheral triggers |
| int_en | input | 1 | Interrupt output enable |
| int_clr | input | 1 | Clears the interrupt flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Access address |
| mem_req_size | output | 2 | Access size code |
| mem_req_wdata | output | DW | Write data, low lanes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | DW | Read data, low lanes |
| sts_active | output | 1 | Inner loop in service |
| sts_done | output | 1 | Outer run complete |
| sts_cfg_err | output | 1 | Descriptor rejected |
| irq | output | 1 | Interrupt |
| cur_src_addr | output | AW | Working source address |
| cur_dst_addr | output | AW | Working destination address |
| cur_iter | output | IT_W | Working iteration count |

## Verification
Two pairs of events can meet in one cycle. The first is an interrupt clear against the final write of an outer run. The bench holds `int_clr` high across the last inner loop and drops it only when done is seen, so the clear and the set land on the same edge; `irq` must then read high. The second is a new trigger against running service. A second start or peripheral pulse is given while active is high, and the run must complete its outer loop with no further pulse, moving exactly the full byte total.

// File: rtl/dnl_pkg.sv
package dnl_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_READ  = 2'd1,
    ENG_RWAIT = 2'd2,
    ENG_WRITE = 2'd3
  } eng_state_e;

  // size code to byte count (code 3 gives 8 and is rejected by the checker)
  function automatic logic [3:0] size_to_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/dnl_cfg_check.sv
module dnl_cfg_check
  import dnl_pkg::*;
#(
  parameter int BC_W     = 16,
  parameter int IT_W     = 15,
  parameter int MAX_CODE = 2
) (
  input  logic [1:0]      src_code,
  input  logic [1:0]      dst_code,
  input  logic [BC_W-1:0] minor_bytes,
  input  logic [IT_W-1:0] major_iters,
  output logic            cfg_ok
);

  localparam logic [1:0] MAX_C = 2'(MAX_CODE);

  logic [1:0]      big_code;
  logic [BC_W-1:0] big_bytes;
  logic            codes_ok;
  logic            aligned;

  always_comb begin
    big_code  = (src_code > dst_code) ? src_code : dst_code;
    big_bytes = BC_W'(size_to_bytes(big_code));
    codes_ok  = (src_code <= MAX_C) && (dst_code <= MAX_C);
    aligned   = (minor_bytes & (big_bytes - BC_W'(1))) == '0;
    cfg_ok    = codes_ok && aligned && (minor_bytes != '0) && (major_iters != '0);
  end

endmodule

// File: rtl/dnl_byte_packer.sv
module dnl_byte_packer #(
  parameter int NB = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [CW-1:0]      push_n,
  input  logic [8*NB-1:0]    push_data,
  input  logic               take,
  input  logic [CW-1:0]      take_n,
  output logic [8*NB-1:0]    take_data,
  output logic [CW-1:0]      fill
);

  localparam int CW = $clog2(NB) + 1;
  localparam int LW = 8 * NB;

  logic [LW-1:0] data_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [LW-1:0] lane_mask(input logic [CW-1:0] n);
    logic [LW-1:0] m;
    for (int i = 0; i < NB; i++) begin
      m[8*i +: 8] = (i < int'(n)) ? 8'hFF : 8'h00;
    end
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (push) begin
      data_q <= data_q | ((push_data & lane_mask(push_n)) << {cnt_q, 3'b000});
      cnt_q  <= cnt_q + push_n;
    end else if (take) begin
      data_q <= data_q >> {take_n, 3'b000};
      cnt_q  <= cnt_q - take_n;
    end
  end

  assign take_data = data_q & lane_mask(take_n);
  assign fill      = cnt_q;

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NB));

  assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cnt_q >= take_n));

endmodule

// File: rtl/dnl_status.sv
module dnl_status (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_start,
  input  logic hw_req,
  input  logic hw_req_en,
  input  logic int_en,
  input  logic int_clr,
  input  logic cfg_load,
  input  logic begin_svc,
  input  logic cfg_fail,
  input  logic minor_end,
  input  logic major_end,
  output logic go,
  output logic active,
  output logic done,
  output logic cfg_err,
  output logic irq
);

  logic start_q, hwp_q, active_q, done_q, err_q, irq_q;
  logic consume;

  assign consume = begin_svc | cfg_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      hwp_q    <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      // new triggers take precedence over consumption
      if (sw_start)     start_q <= 1'b1;
      else if (consume) start_q <= 1'b0;

      if (hw_req && hw_req_en) hwp_q <= 1'b1;
      else if (consume)        hwp_q <= 1'b0;

      if (begin_svc)      active_q <= 1'b1;
      else if (minor_end) active_q <= 1'b0;

      if (major_end)                  done_q <= 1'b1;
      else if (begin_svc || cfg_load) done_q <= 1'b0;

      if (cfg_fail)      err_q <= 1'b1;
      else if (cfg_load) err_q <= 1'b0;

      if (major_end)    irq_q <= 1'b1;
      else if (int_clr) irq_q <= 1'b0;
    end
  end

  assign go      = start_q | hwp_q;
  assign active  = active_q;
  assign done    = done_q;
  assign cfg_err = err_q;
  assign irq     = irq_q & int_en;

  assert_active_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(active_q && done_q));

  assert_irq_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    major_end |=> irq_q);

  assert_fail_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fail |=> (!active_q && err_q));

  assert_trigger_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req && hw_req_en) |=> go);

endmodule

// File: rtl/dma_nested_loop_chan.sv
module dma_nested_loop_chan
  import dnl_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int BC_W = 16,
  parameter int IT_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cfg_src_addr,
  input  logic [AW-1:0]   cfg_dst_addr,
  input  logic [1:0]      cfg_src_size,
  input  logic [1:0]      cfg_dst_size,
  input  logic [BC_W-1:0] cfg_minor_bytes,
  input  logic [IT_W-1:0] cfg_major_iters,
  input  logic [AW-1:0]   cfg_src_final_adj,
  input  logic [AW-1:0]   cfg_dst_final_adj,
  input  logic            cfg_load,
  input  logic            sw_start,
  input  logic            hw_req,
  input  logic            hw_req_en,
  input  logic            int_en,
  input  logic            int_clr,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [1:0]      mem_req_size,
  output logic [DW-1:0]   mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_rdata,
  output logic            sts_active,
  output logic            sts_done,
  output logic            sts_cfg_err,
  output logic            irq,
  output logic [AW-1:0]   cur_src_addr,
  output logic [AW-1:0]   cur_dst_addr,
  output logic [IT_W-1:0] cur_iter
);

  localparam int NB       = DW / 8;
  localparam int CW       = $clog2(NB) + 1;
  localparam int MAX_CODE = $clog2(NB);

  eng_state_e      state_q;
  logic [AW-1:0]   src_q, dst_q;
  logic [IT_W-1:0] iter_q;
  logic [BC_W-1:0] rem_q;

  logic [3:0]      sb, db;
  logic [CW-1:0]   sb_n, db_n, fill;
  logic            go, cfg_ok, idle, load_ok;
  logic            begin_svc, cfg_fail, rd_fire, rsp_take, wr_fire;
  logic            minor_end, major_end;
  logic            enough_after_rd, enough_after_wr;

  assign sb   = size_to_bytes(cfg_src_size);
  assign db   = size_to_bytes(cfg_dst_size);
  assign sb_n = CW'(sb);
  assign db_n = CW'(db);

  assign idle      = (state_q == ENG_IDLE);
  assign load_ok   = cfg_load && idle;
  assign begin_svc = idle && go && !cfg_load && cfg_ok;
  assign cfg_fail  = idle && go && !cfg_load && !cfg_ok;
  assign rd_fire   = (state_q == ENG_READ) && mem_req_ready;
  assign rsp_take  = (state_q == ENG_RWAIT) && mem_rsp_valid;
  assign wr_fire   = (state_q == ENG_WRITE) && mem_req_ready;
  assign minor_end = wr_fire && (rem_q == BC_W'(db));
  assign major_end = minor_end && (iter_q == IT_W'(1));

  assign enough_after_rd = (int'(fill) + int'(sb)) >= int'(db);
  assign enough_after_wr = (int'(fill) - int'(db)) >= int'(db);

  dnl_cfg_check #(
    .BC_W     (BC_W),
    .IT_W     (IT_W),
    .MAX_CODE (MAX_CODE)
  ) u_check (
    .src_code    (cfg_src_size),
    .dst_code    (cfg_dst_size),
    .minor_bytes (cfg_minor_bytes),
    .major_iters (cfg_major_iters),
    .cfg_ok      (cfg_ok)
  );

  dnl_byte_packer #(.NB(NB)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (begin_svc),
    .push      (rsp_take),
    .push_n    (sb_n),
    .push_data (mem_rsp_rdata),
    .take      (wr_fire),
    .take_n    (db_n),
    .take_data (mem_req_wdata),
    .fill      (fill)
  );

  dnl_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_start  (sw_start),
    .hw_req    (hw_req),
    .hw_req_en (hw_req_en),
    .int_en    (int_en),
    .int_clr   (int_clr),
    .cfg_load  (load_ok),
    .begin_svc (begin_svc),
    .cfg_fail  (cfg_fail),
    .minor_end (minor_end),
    .major_end (major_end),
    .go        (go),
    .active    (sts_active),
    .done      (sts_done),
    .cfg_err   (sts_cfg_err),
    .irq       (irq)
  );

  // access sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
    end else begin
      case (state_q)
        ENG_IDLE:  if (begin_svc) state_q <= ENG_READ;
        ENG_READ:  if (rd_fire)   state_q <= ENG_RWAIT;
        ENG_RWAIT: if (rsp_take)  state_q <= enough_after_rd ? ENG_WRITE : ENG_READ;
        ENG_WRITE: begin
          if (minor_end)    state_q <= ENG_IDLE;
          else if (wr_fire) state_q <= enough_after_wr ? ENG_WRITE : ENG_READ;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  // address and loop counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      iter_q <= '0;
      rem_q  <= '0;
    end else begin
      if (load_ok) begin
        src_q  <= cfg_src_addr;
        dst_q  <= cfg_dst_addr;
        iter_q <= cfg_major_iters;
      end else if (rd_fire) begin
        src_q <= src_q + AW'(sb);
      end else if (wr_fire) begin
        dst_q <= dst_q + AW'(db) + (major_end ? cfg_dst_final_adj : '0);
        if (major_end) src_q <= src_q + cfg_src_final_adj;
        if (minor_end) iter_q <= major_end ? cfg_major_iters : iter_q - IT_W'(1);
      end

      if (begin_svc)    rem_q <= cfg_minor_bytes;
      else if (wr_fire) rem_q <= rem_q - BC_W'(db);
    end
  end

  assign mem_req_valid = (state_q == ENG_READ) || (state_q == ENG_WRITE);
  assign mem_req_write = (state_q == ENG_WRITE);
  assign mem_req_addr  = mem_req_write ? dst_q : src_q;
  assign mem_req_size  = mem_req_write ? cfg_dst_size : cfg_src_size;
  assign cur_src_addr  = src_q;
  assign cur_dst_addr  = dst_q;
  assign cur_iter      = iter_q;

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

endmodule

// File: tb/dma_nested_loop_chan_tb_top.sv
module dma_nested_loop_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_src_addr = 32'h1000, cfg_dst_addr = 32'h2000;
  logic [1:0]  cfg_src_size = 2'd0, cfg_dst_size = 2'd2;
  logic [15:0] cfg_minor_bytes = 16'd8;
  logic [14:0] cfg_major_iters = 15'd2;
  logic [31:0] cfg_src_final_adj = 32'hFFFF_FFF0, cfg_dst_final_adj = 32'hFFFF_FFF0;
  logic        cfg_load = 0, sw_start = 0, hw_req = 0, hw_req_en = 0, int_en = 0, int_clr = 0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_rdata = 0;
  logic        sts_active, sts_done, sts_cfg_err, irq;
  logic [31:0] cur_src_addr, cur_dst_addr;
  logic [14:0] cur_iter;

  int n_chk = 0, n_fail = 0;
  int nwr = 0, nrd = 0, nreq = 0, viol = 0, cyc = 0;
  logic [31:0] wa [0:511];
  logic [31:0] wd [0:511];
  logic [31:0] ra [0:511];

  dma_nested_loop_chan dut_i (.*);

  initial forever #5 clk = ~clk;

  function automatic logic [7:0] src_byte(input logic [31:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8];
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] a, input int nbytes);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++) if (j < nbytes) w[8*j +: 8] = src_byte(a + 32'(j));
    return w;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: ready pattern, read latency 0 or 1 extra cycle
  initial begin
    int rd_delay;
    logic rd_outst;
    logic [31:0] rd_addr;
    int rd_size;
    logic rdy;
    rd_outst = 0; rd_delay = 0; rd_addr = 0; rd_size = 1;
    forever begin
      @(negedge clk);
      cyc++;
      if (rd_outst && mem_req_valid) viol++;
      mem_rsp_valid = 1'b0;
      if (rd_outst) begin
        if (rd_delay == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = word_at(rd_addr, rd_size);
          rd_outst = 0;
        end else rd_delay--;
      end
      rdy = (cyc % 3) != 1;
      if (mem_req_valid && rdy && rst_n) begin
        nreq++;
        if (mem_req_write) begin
          if (nwr < 512) begin wa[nwr] = mem_req_addr; wd[nwr] = mem_req_wdata; end
          nwr++;
        end else begin
          if (nrd < 512) ra[nrd] = mem_req_addr;
          nrd++;
          rd_outst = 1; rd_delay = cyc % 2; rd_addr = mem_req_addr;
          rd_size = 1 << mem_req_size;
        end
      end
      mem_req_ready = rdy;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog: actual=%0d cycles expected=completion", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic pulse_hw();
    @(negedge clk) hw_req = 1'b1;
    @(negedge clk) hw_req = 1'b0;
  endtask

  task automatic pulse_sw();
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
  endtask

  task automatic load_desc(input int ss, input int ds, input int nb);
    @(negedge clk);
    cfg_src_size = 2'(ss); cfg_dst_size = 2'(ds); cfg_minor_bytes = 16'(nb);
    cfg_load = 1'b1;
    @(negedge clk) cfg_load = 1'b0;
  endtask

  task automatic wait_quiet(input int target);
    while (!(nwr >= target && !sts_active)) @(negedge clk);
  endtask

  task automatic run_cfg(input int ss, input int ds);
    int sb, db, w0, r0, v0, bad_d, bad_a, bad_r;
    sb = 1 << ss; db = 1 << ds;
    int_en = 1'b1; hw_req_en = 1'b1;
    load_desc(ss, ds, 8);
    w0 = nwr; r0 = nrd; v0 = viol;
    pulse_hw();
    wait_quiet(w0 + 8 / db);
    chk("R4", "iter after first inner loop", 32'(cur_iter), 32'd1);
    chk("R2", "src after first inner loop", cur_src_addr, 32'h1008);
    chk("R2", "dst after first inner loop", cur_dst_addr, 32'h2008);
    chk("R3", "active/done after first inner loop", {30'd0, sts_active, sts_done}, 32'd0);
    pulse_hw();
    wait_quiet(w0 + 16 / db);
    chk("R6", "done at outer completion", 32'(sts_done), 32'd1);
    chk("R7", "irq enabled at completion", 32'(irq), 32'd1);
    chk("R4", "iter reload", 32'(cur_iter), 32'd2);
    chk("R5", "src restored", cur_src_addr, 32'h1000);
    chk("R5", "dst restored", cur_dst_addr, 32'h2000);
    chk("R3", "write count", 32'(nwr - w0), 32'(16 / db));
    chk("R2", "read count", 32'(nrd - r0), 32'(16 / sb));
    bad_d = 0; bad_a = 0; bad_r = 0;
    for (int k = 0; k < 16 / db; k++) begin
      if (wd[w0 + k] !== word_at(32'h1000 + 32'(k * db), db)) bad_d++;
      if (wa[w0 + k] !== 32'h2000 + 32'(k * db)) bad_a++;
    end
    for (int k = 0; k < 16 / sb; k++)
      if (ra[r0 + k] !== 32'h1000 + 32'(k * sb)) bad_r++;
    chk("R1", $sformatf("packed data mismatches ss=%0d ds=%0d", ss, ds), 32'(bad_d), 32'd0);
    chk("R2", "write address mismatches", 32'(bad_a), 32'd0);
    chk("R2", "read address mismatches", 32'(bad_r), 32'd0);
    chk("R12", "issue during outstanding read", 32'(viol - v0), 32'd0);
    @(negedge clk) int_clr = 1'b1;
    @(negedge clk) int_clr = 1'b0;
    chk("R8", "irq after clear", 32'(irq), 32'd0);
  endtask

  initial begin
    int n0, w0;
    repeat (4) @(negedge clk);
    chk("R3", "reset active", 32'(sts_active), 32'd0);
    chk("R6", "reset done", 32'(sts_done), 32'd0);
    chk("R11", "reset cfg_err", 32'(sts_cfg_err), 32'd0);
    chk("R7", "reset irq", 32'(irq), 32'd0);
    chk("R12", "reset request valid", 32'(mem_req_valid), 32'd0);
    chk("R4", "reset iter", 32'(cur_iter), 32'd0);
    rst_n = 1'b1;

    for (int ss = 0; ss < 3; ss++)
      for (int ds = 0; ds < 3; ds++)
        run_cfg(ss, ds);

    // R11: byte count not a multiple of the larger size
    load_desc(0, 2, 6);
    n0 = nreq;
    pulse_hw();
    repeat (6) @(negedge clk);
    chk("R11", "cfg_err set", 32'(sts_cfg_err), 32'd1);
    chk("R11", "no start on bad config", 32'(sts_active), 32'd0);
    chk("R11", "no access on bad config", 32'(nreq - n0), 32'd0);
    load_desc(0, 2, 8);
    chk("R11", "cfg_err cleared by load", 32'(sts_cfg_err), 32'd0);
    repeat (6) @(negedge clk);
    chk("R11", "dropped trigger stays dropped", 32'(nreq - n0), 32'd0);

    // R10: peripheral request while disabled
    hw_req_en = 1'b0;
    pulse_hw();
    repeat (6) @(negedge clk);
    chk("R10", "no access while disabled", 32'(nreq - n0), 32'd0);
    hw_req_en = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10", "disabled request not remembered", 32'(nreq - n0), 32'd0);
    chk("R10", "iter untouched", 32'(cur_iter), 32'd2);

    // R9 and R7: held software start, interrupt disabled
    int_en = 1'b0;
    w0 = nwr;
    pulse_sw();
    while (!sts_active) @(negedge clk);
    pulse_sw();
    wait_quiet(w0 + 4);
    repeat (3) @(negedge clk);
    chk("R9", "held start completes outer run", {31'd0, sts_done}, 32'd1);
    chk("R9", "writes for held start", 32'(nwr - w0), 32'd4);
    chk("R7", "irq gated off", 32'(irq), 32'd0);
    @(negedge clk) int_en = 1'b1;
    #1;
    chk("R7", "flag kept while gated", 32'(irq), 32'd1);
    @(negedge clk) int_clr = 1'b1;
    @(negedge clk) int_clr = 1'b0;

    // R8: clear held across the completing edge
    load_desc(0, 2, 8);
    w0 = nwr;
    pulse_hw();
    wait_quiet(w0 + 2);
    @(negedge clk) int_clr = 1'b1;
    pulse_hw();
    while (!sts_done) @(negedge clk);
    int_clr = 1'b0;
    chk("R8", "set wins over clear", 32'(irq), 32'd1);
    @(negedge clk);
    chk("R8", "flag remains after clear released", 32'(irq), 32'd1);
    chk("R9", "held hw request writes", 32'(nwr - w0), 32'd4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule